// File: doc/BRIEF.md
# GPIO Pin Controller Register Bank

This block holds the software-visible state for a bank of general-purpose pins (94 by default, set by a parameter) and drives the pad controls from that state. A host reaches it through a plain 32-bit read/write port. Each read returns its data one clock later. The address space has two parts. The first is a small group of bank-wide bitmap words at the bottom of the map, with one bit per pin. The second is a region starting at 0x100 that gives every pin two consecutive 32-bit configuration words.

The bitmap area holds the host-ownership map. Strap inputs set this map while reset is held, and the bus cannot change it. The first configuration word of a pin holds the output level, the direction and a GPIO-versus-native select. It also returns the synchronized input level. The second configuration word holds an input-sense disable and a two-bit weak-pull code. On the pad side the block drives the output value, the output enable, the pull code, the sense enable and the native/GPIO select. It samples each pad input through a two-flop synchronizer. Interrupt detection lives in a separate block.

Top module: `gpio_bank_regs`

## Requirements
- R1: The ownership word for pin p is at byte offset (p/32)*4, and the pin's bit is p%32 in that word. A 1 means the host owns the pin. The map holds the strap value captured during reset. Bus writes to these words are ignored. Bits for pins at or above NUM_PINS read 0.
- R2: Once reset is released, the ownership map never changes, even when the strap inputs change.
- R3: The first configuration word of pin p is at 0x100 + 8p. Bit 31 (output level), bit 2 (direction, 1 = input) and bit 0 (use, 1 = GPIO) are read/write. All bits other than 30, 31, 2 and 0 read 0. After reset the word reads 0x00000004.
- R4: The second configuration word of pin p is at 0x104 + 8p. Bit 2 (sense disable) and bits [1:0] (pull code) are read/write, and all other bits read 0. After reset the word reads 0x00000004. The pull code drives pad_pull[2p+1:2p], and pad_sense_en[p] is the inverse of bit 2.
- R5: Bit 30 of the first configuration word is read-only. It shows pad_in[p] after two register stages. A read issued in the same cycle as an input change, or in the cycle after it, still returns the old level. Bit 30 reads 0 while sensing is disabled.
- R6: pad_oe[p] is 1 exactly when the pin is in GPIO mode, its direction is output and the host owns it. pad_out[p] equals the output level bit while pad_oe[p] is 1, and is 0 otherwise.
- R7: Reads of any offset outside the ownership words and the configuration slots of existing pins return 0, and writes to those offsets change nothing. This covers 0x7C, a fourth bitmap word, and slot NUM_PINS. Address bits [1:0] are ignored.
- R8: bus_rdata updates only on the clock edge that samples bus_rd, and holds its value through idle cycles and writes.
- R9: pad_gpio_mode[p] follows the use bit of pin p. After reset every pin is in native mode with its output disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; straps are sampled while low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| own_strap | input | NUM_PINS | Host-ownership straps |
| pad_in | input | NUM_PINS | Asynchronous pad inputs |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| pad_pull | output | 2*NUM_PINS | Weak-pull code, two bits per pin |
| pad_sense_en | output | NUM_PINS | Input sense enables |
| pad_gpio_mode | output | NUM_PINS | 1 = GPIO, 0 = native function |

## Verification
The hardest case to reach from the ports is the two-stage latency on the input level. It only shows when a read lands in the first or second cycle after a pad change, on a pin whose sensing was enabled beforehand. The bench enables sensing on one pin and changes that pad in the same half-cycle as a read strobe. It then issues back-to-back reads and expects the old level twice before the new one appears. The output-enable gating on ownership needs a non-owned pin to be placed in GPIO output mode. The bench therefore straps a few pins as firmware-reserved and drives each of the three enable conditions separately.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   // first per-pin word
   localparam int C1_OUT_BIT = 31;
   localparam int C1_IN_BIT  = 30;
   localparam int C1_DIR_BIT = 2;
   localparam int C1_USE_BIT = 0;
   // second per-pin word
   localparam int C2_SDIS_BIT = 2;
   localparam int PULL_W      = 2;
   // map
   localparam int CFG_BASE   = 'h100;
   localparam int SLOT_BYTES = 8;

   typedef struct packed {
      logic              out_lvl;
      logic              dir_in;
      logic              use_gpio;
      logic              sense_dis;
      logic [PULL_W-1:0] pull;
   } pin_cfg_t;

   localparam pin_cfg_t CFG_RESET = '{out_lvl: 1'b0, dir_in: 1'b1, use_gpio: 1'b0,
                                      sense_dis: 1'b1, pull: '0};
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1 <= '0;
         q      <= '0;
      end else begin
         stage1 <= d;
         q      <= stage1;
      end
   end
endmodule

// File: rtl/gpio_own_map.sv
module gpio_own_map #(
   parameter int NUM_PINS  = 94,
   parameter int NUM_WORDS = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_PINS-1:0]    strap,
   output logic [NUM_PINS-1:0]    own,
   output logic [NUM_WORDS*32-1:0] own_words
);
   // straps are sampled on every edge while reset is held, then frozen
   always_ff @(posedge clk) begin
      if (!rst_n) own <= strap;
   end

   assign own_words = (NUM_WORDS*32)'(own);
endmodule

// File: rtl/gpio_pin_slot.sv
module gpio_pin_slot
   import gpio_bank_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_c1,
   input  logic              wr_c2,
   input  logic [31:0]       wdata,
   input  logic              owned,
   input  logic              in_sync,
   output logic [31:0]       rd_c1,
   output logic [31:0]       rd_c2,
   output logic              pad_out,
   output logic              pad_oe,
   output logic [PULL_W-1:0] pad_pull,
   output logic              sense_en,
   output logic              gpio_mode
);
   pin_cfg_t cfg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= CFG_RESET;
      end else begin
         if (wr_c1) begin
            cfg.out_lvl  <= wdata[C1_OUT_BIT];
            cfg.dir_in   <= wdata[C1_DIR_BIT];
            cfg.use_gpio <= wdata[C1_USE_BIT];
         end
         if (wr_c2) begin
            cfg.sense_dis <= wdata[C2_SDIS_BIT];
            cfg.pull      <= wdata[PULL_W-1:0];
         end
      end
   end

   always_comb begin
      rd_c1             = '0;
      rd_c1[C1_OUT_BIT] = cfg.out_lvl;
      rd_c1[C1_IN_BIT]  = in_sync & ~cfg.sense_dis;
      rd_c1[C1_DIR_BIT] = cfg.dir_in;
      rd_c1[C1_USE_BIT] = cfg.use_gpio;
      rd_c2               = '0;
      rd_c2[C2_SDIS_BIT]  = cfg.sense_dis;
      rd_c2[PULL_W-1:0]   = cfg.pull;
   end

   assign pad_oe    = cfg.use_gpio & ~cfg.dir_in & owned;
   assign pad_out   = pad_oe & cfg.out_lvl;
   assign pad_pull  = cfg.pull;
   assign sense_en  = ~cfg.sense_dis;
   assign gpio_mode = cfg.use_gpio;
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS = 94,
   parameter int ADDR_W   = 12
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_wr,
   input  logic                       bus_rd,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic [31:0]                bus_wdata,
   output logic [31:0]                bus_rdata,
   input  logic [NUM_PINS-1:0]        own_strap,
   input  logic [NUM_PINS-1:0]        pad_in,
   output logic [NUM_PINS-1:0]        pad_out,
   output logic [NUM_PINS-1:0]        pad_oe,
   output logic [PULL_W*NUM_PINS-1:0] pad_pull,
   output logic [NUM_PINS-1:0]        pad_sense_en,
   output logic [NUM_PINS-1:0]        pad_gpio_mode
);
   localparam int NUM_WORDS = (NUM_PINS + 31) / 32;
   localparam int WORD_IW   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
   localparam int PIN_IW    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
   localparam int CFG_END   = CFG_BASE + NUM_PINS * SLOT_BYTES;
   localparam logic [ADDR_W-1:0] OWN_LIMIT = ADDR_W'(NUM_WORDS * 4);
   localparam logic [ADDR_W-1:0] CFG_LO    = ADDR_W'(CFG_BASE);
   localparam logic [ADDR_W-1:0] CFG_HI    = ADDR_W'(CFG_END);

   // elaboration-time parameter checks
   if (NUM_PINS < 1) begin : g_bad_pins
      $error("NUM_PINS must be at least 1");
   end
   if (NUM_WORDS * 4 > CFG_BASE) begin : g_bad_bitmap
      $error("bitmap words overlap the configuration region");
   end
   if (CFG_END > (1 << ADDR_W) || ADDR_W < PIN_IW + 3) begin : g_bad_addr
      $error("ADDR_W too small for NUM_PINS");
   end

   // decode
   logic [ADDR_W-1:0]  word_addr, cfg_rel;
   logic               hit_own, hit_cfg, sel_c2;
   logic [PIN_IW-1:0]  pin_idx;
   logic [WORD_IW-1:0] word_idx;

   assign word_addr = {bus_addr[ADDR_W-1:2], 2'b00};
   assign hit_own   = word_addr < OWN_LIMIT;
   assign hit_cfg   = (word_addr >= CFG_LO) && (word_addr < CFG_HI);
   assign cfg_rel   = word_addr - CFG_LO;
   assign pin_idx   = cfg_rel[PIN_IW+2:3];
   assign sel_c2    = word_addr[2];
   assign word_idx  = word_addr[WORD_IW+1:2];

   // ownership
   logic [NUM_PINS-1:0]     own_q;
   logic [NUM_WORDS*32-1:0] own_words;

   gpio_own_map #(.NUM_PINS(NUM_PINS), .NUM_WORDS(NUM_WORDS)) u_own (
      .clk(clk), .rst_n(rst_n), .strap(own_strap),
      .own(own_q), .own_words(own_words)
   );

   // input synchronizer
   logic [NUM_PINS-1:0] in_sync;

   gpio_sync2 #(.W(NUM_PINS)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(in_sync)
   );

   // per-pin slots
   logic [31:0] c1_words [NUM_PINS];
   logic [31:0] c2_words [NUM_PINS];

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic hit_me;
      assign hit_me = bus_wr && hit_cfg && (pin_idx == PIN_IW'(i));

      gpio_pin_slot u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_c1    (hit_me && !sel_c2),
         .wr_c2    (hit_me && sel_c2),
         .wdata    (bus_wdata),
         .owned    (own_q[i]),
         .in_sync  (in_sync[i]),
         .rd_c1    (c1_words[i]),
         .rd_c2    (c2_words[i]),
         .pad_out  (pad_out[i]),
         .pad_oe   (pad_oe[i]),
         .pad_pull (pad_pull[PULL_W*i +: PULL_W]),
         .sense_en (pad_sense_en[i]),
         .gpio_mode(pad_gpio_mode[i])
      );
   end

   // read path
   logic [31:0] rd_next;

   always_comb begin
      rd_next = '0;
      if (hit_own)
         rd_next = own_words[32*word_idx +: 32];
      else if (hit_cfg)
         rd_next = sel_c2 ? c2_words[pin_idx] : c1_words[pin_idx];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_next;
   end
endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk #(
   parameter int NUM_PINS = 94,
   parameter int ADDR_W   = 12
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_rd,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [31:0]         bus_rdata,
   input logic [NUM_PINS-1:0] own_q,
   input logic [NUM_PINS-1:0] pad_out,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic [NUM_PINS-1:0] pad_gpio_mode
);
   localparam int NWORDS = (NUM_PINS + 31) / 32;

   logic [31:0] wa;
   logic        mapped;
   assign wa     = 32'({bus_addr[ADDR_W-1:2], 2'b00});
   assign mapped = (wa < 32'(NWORDS * 4)) ||
                   ((wa >= 32'h100) && (wa < 32'(256 + NUM_PINS * 8)));

   p_own_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(own_q));

   p_oe_gpio_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & ~pad_gpio_mode) == '0);

   p_oe_owned_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & ~own_q) == '0);

   p_out_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_out & ~pad_oe) == '0);

   p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !mapped) |=> (bus_rdata == '0));

   p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
   .bus_rdata(bus_rdata), .own_q(own_q), .pad_out(pad_out), .pad_oe(pad_oe),
   .pad_gpio_mode(pad_gpio_mode)
);

// File: tb/gpio_bank_regs_test.sv
module gpio_bank_regs_test;
   localparam int NP = 94;
   localparam int AW = 12;

   logic          clk = 0;
   logic          rst_n = 0;
   logic          bus_wr = 0, bus_rd = 0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] own_strap, pad_in = '0;
   logic [NP-1:0] pad_out, pad_oe, pad_sense_en, pad_gpio_mode;
   logic [2*NP-1:0] pad_pull;
   logic [NP-1:0] strap_ref;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   gpio_bank_regs #(.NUM_PINS(NP), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .own_strap(own_strap), .pad_in(pad_in), .pad_out(pad_out),
      .pad_oe(pad_oe), .pad_pull(pad_pull), .pad_sense_en(pad_sense_en),
      .pad_gpio_mode(pad_gpio_mode)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_wr = 0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      bus_rd = 1; bus_addr = AW'(a);
      @(posedge clk); @(negedge clk);
      bus_rd = 0;
      d = bus_rdata;
   endtask

   function automatic logic [31:0] own_exp(input int w);
      logic [31:0] v = '0;
      for (int b = 0; b < 32; b++)
         if (32*w + b < NP) v[b] = strap_ref[32*w + b];
      return v;
   endfunction

   task automatic t_reset();
      logic [31:0] d;
      check("R9 oe after reset", 32'(pad_oe), 32'h0);
      check("R9 gpio_mode after reset", 32'(pad_gpio_mode), 32'h0);
      check("R4 sense_en after reset", 32'(pad_sense_en), 32'h0);
      check("R4 pull after reset", 32'(pad_pull != '0), 32'h0);
      rd('h100, d); check("R3 cfg1 reset pin0", d, 32'h4);
      rd('h3EC, d); check("R4 cfg2 reset pin93", d, 32'h4);
   endtask

   task automatic t_ownership();
      logic [31:0] d;
      for (int w = 0; w < 3; w++) begin
         rd(4*w, d); check("R1 own word", d, own_exp(w));
      end
      wr('h08, 32'h0); wr('h00, 32'h0);
      rd('h08, d); check("R1 own write ignored w2", d, own_exp(2));
      rd('h00, d); check("R1 own write ignored w0", d, own_exp(0));
      own_strap = '0;
      @(negedge clk);
      rd('h00, d); check("R2 own frozen w0", d, own_exp(0));
      rd('h08, d); check("R2 own frozen w2", d, own_exp(2));
   endtask

   task automatic t_cfg1();
      logic [31:0] d;
      wr('h3E8, 32'hFFFF_FFFF);
      rd('h3E8, d); check("R3 cfg1 pin93 masked", d, 32'h8000_0005);
      check("R9 gpio_mode pin93", 32'(pad_gpio_mode[93]), 32'h1);
      check("R6 oe off when input", 32'(pad_oe[93]), 32'h0);
   endtask

   task automatic t_drive();
      wr('h150, 32'h8000_0001);
      check("R6 oe pin10", 32'(pad_oe[10]), 32'h1);
      check("R6 out pin10 high", 32'(pad_out[10]), 32'h1);
      wr('h150, 32'h0000_0001);
      check("R6 out pin10 low", 32'(pad_out[10]), 32'h0);
      check("R6 oe pin10 kept", 32'(pad_oe[10]), 32'h1);
      wr('h128, 32'h8000_0001);
      check("R6 not owned pin5 oe", 32'(pad_oe[5]), 32'h0);
      check("R6 not owned pin5 out", 32'(pad_out[5]), 32'h0);
      wr('h158, 32'h8000_0000);
      check("R6 native pin11 oe", 32'(pad_oe[11]), 32'h0);
      check("R9 native pin11", 32'(pad_gpio_mode[11]), 32'h0);
   endtask

   task automatic t_cfg2();
      logic [31:0] d;
      wr('h1A4, 32'h0000_0003);
      rd('h1A4, d); check("R4 cfg2 pin20", d, 32'h3);
      check("R4 pull pin20", 32'(pad_pull[41:40]), 32'h3);
      check("R4 sense_en pin20", 32'(pad_sense_en[20]), 32'h1);
      wr('h1AC, 32'hFFFF_FFFF);
      rd('h1AC, d); check("R4 cfg2 pin21 masked", d, 32'h7);
      check("R4 sense_en pin21 off", 32'(pad_sense_en[21]), 32'h0);
   endtask

   task automatic t_input();
      logic [31:0] d;
      pad_in[20] = 1'b1;
      rd('h1A0, d); check("R5 latency read1", d, 32'h4);
      rd('h1A0, d); check("R5 latency read2", d, 32'h4);
      rd('h1A0, d); check("R5 level seen", d, 32'h4000_0004);
      pad_in[21] = 1'b1;
      repeat (3) @(negedge clk);
      rd('h1A8, d); check("R5 sense off pin21", d, 32'h4);
      wr('h1A4, 32'h4);
      rd('h1A0, d); check("R5 sense disabled pin20", d, 32'h4);
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      rd('h3E8, d);
      repeat (3) @(negedge clk);
      wr('h150, 32'h8000_0001);
      check("R8 rdata held", bus_rdata, 32'h8000_0005);
      rd('h07C, d); check("R7 0x7C", d, 32'h0);
      rd('h00C, d); check("R7 bitmap word3", d, 32'h0);
      wr('h3F0, 32'hFFFF_FFFF); wr('h3F4, 32'hFFFF_FFFF);
      rd('h3F0, d); check("R7 slot94 cfg1", d, 32'h0);
      rd('h3F4, d); check("R7 slot94 cfg2", d, 32'h0);
      rd('h3EC, d); check("R7 pin93 cfg2 intact", d, 32'h4);
      rd('h3EB, d); check("R7 low addr bits ignored", d, 32'h8000_0005);
   endtask

   initial begin
      strap_ref = '1;
      strap_ref[5] = 1'b0; strap_ref[70] = 1'b0; strap_ref[93] = 1'b0;
      own_strap = strap_ref;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_ownership();
      t_cfg1();
      t_drive();
      t_cfg2();
      t_input();
      t_unmapped();
      done = 1;
   end

   initial begin
      for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule